// File: doc/BRIEF.md
# Programmable Delay Tap Controller

This block is the control side of a 32-step output delay line. It holds a 5-bit tap index and changes it on the edges of a control clock, from a step request, an up/down select, a load strobe and a 5-bit load value. A separate delay model reads the index to pick which tap drives the delayed output. The analog chain itself is not part of the block.

The behaviour is chosen at elaboration by the `MODE` parameter, which has four settings.
- **Fixed:** the index stays at `INIT_TAP` and every control input is ignored.
- **Step:** the index moves one tap up or down on request, and a load puts it back to `INIT_TAP`.
- **Direct load:** stepping works as in step mode, and a load takes the index from the load value.
- **Staged load:** stepping works as in step mode. A staging register first captures the load value, and a load then moves the staged value into the index. The staging register has its own clear input and capture enable.

Top module: `tap_delay_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge the tap index goes to `INIT_TAP` in fixed and step modes, and to 0 in the two load modes. The staging register also goes to 0.
- R2: In fixed mode `tap_sel` always equals `INIT_TAP`, whatever the control inputs do.
- R3: In every mode except fixed, `step_en` high with no load moves the index by one at the next edge. It moves up when `step_up` is 1 and down when it is 0. Stepping up from 31 wraps to 0, and stepping down from 0 wraps to 31.
- R4: When `load_stb` and `step_en` are high in the same cycle, the load wins and no step is applied.
- R5: In step mode, `load_stb` sets the index to `INIT_TAP`.
- R6: In direct-load mode, `load_stb` sets the index to `load_val`. `INIT_TAP` has no effect in this mode.
- R7: In staged mode, `stage_en` captures `load_val` into the staging register. `load_stb` copies into the index the staging value held before that same edge.
- R8: In staged mode, `stage_clr` sets the staging register to 0, or to `load_val` if `stage_en` is high in the same cycle. In the other modes, `stage_en` and `stage_clr` have no effect on the outputs.
- R9: `tap_count` equals the tap index in the two load modes and is 0 in fixed and step modes. `tap_sel` always shows the tap index.
- R10: Every change that a control input causes appears on the outputs one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Request a one-tap move |
| step_up | input | 1 | Step direction: 1 = up, 0 = down |
| load_stb | input | 1 | Load the tap index from the source that the mode selects |
| stage_en | input | 1 | Capture `load_val` into the staging register (staged mode) |
| stage_clr | input | 1 | Clear the staging register (staged mode) |
| load_val | input | 5 | Load value |
| tap_count | output | 5 | Reported tap index (load modes only, else 0) |
| tap_sel | output | 5 | Tap index that drives the delay model |

## Verification
The bench drives the same stimulus into all four modes side by side. It sweeps all 32 load values against every combination of capture, clear and load, and walks the index through both wrap points. A design that lets the step win over a load would leave the index one tap away from the loaded value. A design that loads the staging value captured in the same cycle, or that lets the clear override a simultaneous capture, would put the wrong tap into the index. A design that decrements from 0 into 0 rather than 31, or that reports the index in step mode, fails the boundary and reporting checks.

// File: rtl/dtap_pkg.sv
package dtap_pkg;
    localparam int TAP_W = 5;
    localparam int TAP_N = 1 << TAP_W;

    typedef logic [TAP_W-1:0] tap_t;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_STEP   = 2'd1,
        MODE_LOAD   = 2'd2,
        MODE_STAGED = 2'd3
    } dtap_mode_e;

    typedef struct packed {
        logic step_en;
        logic step_up;
        logic load;
    } tap_req_t;

    function automatic tap_t tap_step(input tap_t t, input logic up);
        return up ? tap_t'(t + 1'b1) : tap_t'(t - 1'b1);
    endfunction

    function automatic logic mode_loadable(input dtap_mode_e m);
        return (m == MODE_LOAD) || (m == MODE_STAGED);
    endfunction
endpackage

// File: rtl/dtap_stage.sv
module dtap_stage
    import dtap_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic clr,
    input  tap_t din,
    output tap_t q
);
    generate
        if (ENABLE) begin : g_stage
            tap_t stage_q;
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q <= '0;
                else if (clr)
                    stage_q <= cap_en ? din : '0;
                else if (cap_en)
                    stage_q <= din;
            end
            assign q = stage_q;

            p_clear_r8: assert property (@(posedge clk) disable iff (rst)
                (clr && !cap_en) |=> (q == '0));
            p_capture_r7: assert property (@(posedge clk) disable iff (rst)
                cap_en |=> (q == $past(din)));
        end else begin : g_none
            assign q = '0;
        end
    endgenerate
endmodule

// File: rtl/dtap_counter.sv
module dtap_counter
    import dtap_pkg::*;
#(
    parameter dtap_mode_e  MODE     = MODE_FIXED,
    parameter int unsigned INIT_TAP = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  tap_req_t req,
    input  tap_t     load_src,
    output tap_t     tap
);
    localparam tap_t INIT_V  = tap_t'(INIT_TAP);
    localparam tap_t RESET_V = mode_loadable(MODE) ? '0 : INIT_V;
    localparam bit   ADJUST  = (MODE != MODE_FIXED);

    tap_t tap_q;

    always_ff @(posedge clk) begin
        if (rst)
            tap_q <= RESET_V;
        else if (ADJUST) begin
            if (req.load)
                tap_q <= load_src;
            else if (req.step_en)
                tap_q <= tap_step(tap_q, req.step_up);
        end
    end
    assign tap = tap_q;

    generate
        if (ADJUST) begin : g_chk
            p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
                (req.step_en && req.step_up && !req.load) |=> (tap == tap_t'($past(tap) + 1'b1)));
            p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
                (req.step_en && !req.step_up && !req.load) |=> (tap == tap_t'($past(tap) - 1'b1)));
            p_load_wins_r4: assert property (@(posedge clk) disable iff (rst)
                req.load |=> (tap == $past(load_src)));
        end else begin : g_fix
            p_fixed_hold_r2: assert property (@(posedge clk) disable iff (rst)
                ##1 $stable(tap));
        end
    endgenerate
endmodule

// File: rtl/tap_delay_ctrl.sv
module tap_delay_ctrl
    import dtap_pkg::*;
#(
    parameter dtap_mode_e  MODE     = MODE_STAGED,
    parameter int unsigned INIT_TAP = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_en,
    input  logic                step_up,
    input  logic                load_stb,
    input  logic                stage_en,
    input  logic                stage_clr,
    input  logic [TAP_W-1:0]    load_val,
    output logic [TAP_W-1:0]    tap_count,
    output logic [TAP_W-1:0]    tap_sel
);
    localparam tap_t INIT_V = tap_t'(INIT_TAP);

    tap_req_t req;
    tap_t     stage_q;
    tap_t     load_src;
    tap_t     tap;

    assign req = '{step_en: step_en, step_up: step_up, load: load_stb};

    dtap_stage #(
        .ENABLE (MODE == MODE_STAGED)
    ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .cap_en (stage_en),
        .clr    (stage_clr),
        .din    (load_val),
        .q      (stage_q)
    );

    generate
        case (MODE)
            MODE_LOAD:   begin : g_src_load   assign load_src = load_val; end
            MODE_STAGED: begin : g_src_stage  assign load_src = stage_q;  end
            default:     begin : g_src_init   assign load_src = INIT_V;   end
        endcase
    endgenerate

    dtap_counter #(
        .MODE     (MODE),
        .INIT_TAP (INIT_TAP)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .load_src (load_src),
        .tap      (tap)
    );

    assign tap_sel   = tap;
    assign tap_count = mode_loadable(MODE) ? tap : '0;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (tap_sel == (mode_loadable(MODE) ? tap_t'(0) : INIT_V)));
    p_report_r9: assert property (@(posedge clk) disable iff (rst)
        mode_loadable(MODE) ? (tap_count == tap_sel) : (tap_count == '0));
endmodule

// File: tb/tap_delay_ctrl_tb.sv
module tap_delay_ctrl_tb;
    import dtap_pkg::*;

    localparam int INIT_F = 19;
    localparam int INIT_S = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 0, step_up = 0, load_stb = 0, stage_en = 0, stage_clr = 0;
    tap_t load_val = '0;
    tap_t cnt_f, sel_f, cnt_s, sel_s, cnt_l, sel_l, cnt_g, sel_g;

    int checks = 0;
    int errors = 0;

    tap_t m_fix, m_step, m_load, m_gtap, m_stg;

    always #4 clk = ~clk;

    tap_delay_ctrl #(.MODE(MODE_STAGED), .INIT_TAP(INIT_S)) u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up), .load_stb(load_stb),
        .stage_en(stage_en), .stage_clr(stage_clr), .load_val(load_val),
        .tap_count(cnt_g), .tap_sel(sel_g));
    tap_delay_ctrl #(.MODE(MODE_LOAD), .INIT_TAP(INIT_S)) u_dut_load (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up), .load_stb(load_stb),
        .stage_en(stage_en), .stage_clr(stage_clr), .load_val(load_val),
        .tap_count(cnt_l), .tap_sel(sel_l));
    tap_delay_ctrl #(.MODE(MODE_STEP), .INIT_TAP(INIT_S)) u_dut_step (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up), .load_stb(load_stb),
        .stage_en(stage_en), .stage_clr(stage_clr), .load_val(load_val),
        .tap_count(cnt_s), .tap_sel(sel_s));
    tap_delay_ctrl #(.MODE(MODE_FIXED), .INIT_TAP(INIT_F)) u_dut_fix (
        .clk(clk), .rst(rst), .step_en(step_en), .step_up(step_up), .load_stb(load_stb),
        .stage_en(stage_en), .stage_clr(stage_clr), .load_val(load_val),
        .tap_count(cnt_f), .tap_sel(sel_f));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic tap_t model_next(input tap_t t, input logic se, input logic su,
                                        input logic ld, input tap_t src);
        int v;
        if (ld) return src;
        if (!se) return t;
        v = su ? (int'(t) + 1) % TAP_N : (int'(t) + TAP_N - 1) % TAP_N;
        return tap_t'(v);
    endfunction

    task automatic compare_all(input string tag);
        chk({"R2 fixed sel ", tag}, int'(sel_f), int'(m_fix));
        chk({"R9 fixed cnt ", tag}, int'(cnt_f), 0);
        chk({"step sel ", tag}, int'(sel_s), int'(m_step));
        chk({"R9 step cnt ", tag}, int'(cnt_s), 0);
        chk({"load sel ", tag}, int'(sel_l), int'(m_load));
        chk({"R9 load cnt ", tag}, int'(cnt_l), int'(m_load));
        chk({"staged sel ", tag}, int'(sel_g), int'(m_gtap));
        chk({"R9 staged cnt ", tag}, int'(cnt_g), int'(m_gtap));
    endtask

    // one control cycle; model updated from pre-edge values (R10: one edge latency)
    task automatic apply(input logic se, input logic su, input logic ld, input logic pe,
                         input logic pc, input tap_t lv, input string tag);
        tap_t old_stg;
        step_en = se; step_up = su; load_stb = ld;
        stage_en = pe; stage_clr = pc; load_val = lv;
        @(posedge clk);
        old_stg = m_stg;
        m_step  = model_next(m_step, se, su, ld, tap_t'(INIT_S));
        m_load  = model_next(m_load, se, su, ld, lv);
        m_gtap  = model_next(m_gtap, se, su, ld, old_stg);
        if (pc)      m_stg = pe ? lv : '0;
        else if (pe) m_stg = lv;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step_en = 0; load_stb = 0; stage_en = 0; stage_clr = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        m_fix = tap_t'(INIT_F); m_step = tap_t'(INIT_S);
        m_load = '0; m_gtap = '0; m_stg = '0;
        compare_all("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_fix = tap_t'(INIT_F);
        @(negedge clk);
        do_reset();

        // R3: step up across the 31->0 wrap, then down across 0->31
        for (int i = 0; i < 40; i++) apply(1, 1, 0, 0, 0, tap_t'(i), "R3 R10 up");
        for (int i = 0; i < 80; i++) apply(1, 0, 0, 0, 0, tap_t'(i), "R3 R10 down");

        // R5/R6: plain loads of every value; staging stays 0 so staged loads 0
        for (int v = 0; v < TAP_N; v++) apply(0, 0, 1, 0, 0, tap_t'(v), "R5 R6 load");

        // R4: load and step together, both directions
        for (int v = 0; v < TAP_N; v++) apply(1, v[0], 1, 0, 0, tap_t'(v), "R4 load+step");

        // R7/R8: every capture/clear/load combination with every load value
        for (int v = 0; v < TAP_N; v++)
            for (int c = 0; c < 8; c++)
                apply(v[1], v[2], c[0], c[1], c[2], tap_t'(v ^ (c * 5)), "R7 R8 stage");

        // R7: capture then transfer, distinct values
        apply(0, 0, 0, 1, 0, tap_t'(21), "R7 capture");
        apply(0, 0, 1, 0, 0, tap_t'(3), "R7 transfer");
        // R8: clear then transfer yields 0; clear+enable keeps the new value
        apply(0, 0, 0, 0, 1, tap_t'(9), "R8 clear");
        apply(0, 0, 1, 0, 0, tap_t'(9), "R8 clear load");
        apply(0, 0, 0, 1, 1, tap_t'(30), "R8 clear+en");
        apply(0, 0, 1, 0, 0, tap_t'(2), "R8 clear+en load");

        // R1: reset from a non-initial state
        apply(1, 1, 0, 0, 0, tap_t'(0), "R3 pre-reset");
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule